// File: doc/BRIEF.md
# Light-Selected Four-Level PWM Generator

This block turns the state of two light sensors into a pulse-width-modulated enable for one motor. Each sensor bit is 1 when its sensor sees light and 0 when it is dark. Together the two bits form a 2-bit level code. The code picks one of four duty levels: stopped, one quarter, one half and full.

The partial duties are built from a frame of four equal time units. A prescaler counts clock cycles to set the length of one unit. A small sequencer samples the level code, plays the on/off pattern of one whole frame, and only then samples again. For the stopped and full levels there is no frame. The sequencer sets the output level and looks at the code again on the very next clock.

The sensor bits come from outside the clock domain, so each one passes through a two-flop synchronizer first.

Top module: `lumen_pwm_top`

## Requirements
- R1: The level code is {sense_i[1], sense_i[0]}. Bit 1 is the more significant bit. A bit reads 1 when its sensor is lit and 0 when it is dark.
- R2: Code 2'b00 holds pwm_o low for as long as the code stays 00.
- R3: Code 2'b01 gives frames in which pwm_o is high for one time unit and then low for three units. While the code is held, frames follow each other with no gap, so the period is exactly four units.
- R4: Code 2'b10 gives frames in which pwm_o is high for two units and then low for two units. The period is exactly four units.
- R5: Code 2'b11 holds pwm_o high for as long as the code stays 11.
- R6: One time unit lasts exactly TICK_CYCLES clock cycles (default 255).
- R7: A frame started by code 01 or 10 keeps the code it latched until its fourth unit ends. A code change in the middle of a frame takes effect only at the frame boundary.
- R8: While the sequencer is not inside a frame, it re-evaluates the code on every clock. A change applied to sense_i reaches pwm_o on the third rising clock edge after it is applied: two synchronizer stages plus the output register.
- R9: Each sensor bit is synchronized by two flops before it is used.
- R10: Synchronous reset drives pwm_o low and puts the sequencer in its sampling state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_i | input | 2 | Sensor bits, 1 = lit; bit 1 is the MSB of the level code |
| pwm_o | output | 1 | Registered motor-enable waveform |

## Verification
The assertions assume that sense_i is a level that stays fixed for more than a couple of cycles around each change. They also assume that reset is held for at least two clocks, so the synchronizer holds known values. The bench drives sense_i only on falling clock edges. It keeps every random code for several whole frames, and it changes a code mid-frame only at chosen offsets, so each measured high and low run can be traced to exactly one latched code. The bench also holds reset for several cycles before releasing it.

// File: rtl/lumen_pwm_pkg.sv
package lumen_pwm_pkg;

    localparam int FRAME_UNITS = 4;
    localparam int UNIT_W      = $clog2(FRAME_UNITS);

    typedef logic [1:0] level_code_t;

    typedef enum logic {
        ST_SAMPLE = 1'b0,
        ST_FRAME  = 1'b1
    } seq_state_t;

    typedef struct packed {
        seq_state_t        st;
        level_code_t       code;
        logic [UNIT_W-1:0] unit;
        logic              pwm;
    } seq_regs_t;

    // Number of high units in a frame for a code
    function automatic logic [2:0] on_units(input level_code_t c);
        case (c)
            2'b01:   on_units = 3'd1;
            2'b10:   on_units = 3'd2;
            2'b11:   on_units = 3'd4;
            default: on_units = 3'd0;
        endcase
    endfunction

    // Decision taken whenever the code is (re)sampled
    function automatic seq_regs_t pick_level(input level_code_t c);
        seq_regs_t r;
        r.code = c;
        r.unit = '0;
        case (c)
            2'b00: begin r.st = ST_SAMPLE; r.pwm = 1'b0; end
            2'b11: begin r.st = ST_SAMPLE; r.pwm = 1'b1; end
            default: begin r.st = ST_FRAME; r.pwm = 1'b1; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lumen_sync.sv
module lumen_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[b] <= 1'b0;
                stage2_q[b] <= 1'b0;
            end else begin
                stage1_q[b] <= async_i[b];
                stage2_q[b] <= stage1_q[b];
            end
        end
    end

    assign sync_o = stage2_q;

    // cycles since reset, saturating, to guard the two-deep $past
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)               warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (sync_o == $past(async_i, 2)));

endmodule

// File: rtl/lumen_prescaler.sv
module lumen_prescaler #(
    parameter int TICK_CYCLES = 255
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic tick_o
);

    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i)   cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    assert_tick_wraps_R6: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !restart_i) |=> (cnt_q == '0));

endmodule

// File: rtl/lumen_sequencer.sv
module lumen_sequencer
    import lumen_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  level_code_t code_i,
    input  logic        tick_i,
    output logic        restart_o,
    output logic        pwm_o
);

    seq_regs_t cur_q;
    seq_regs_t nxt;
    logic      frame_end;
    logic [2:0] next_unit;

    assign frame_end = (cur_q.st == ST_FRAME) && tick_i
                       && (cur_q.unit == UNIT_W'(FRAME_UNITS - 1));
    assign next_unit = {1'b0, cur_q.unit} + 3'd1;

    always_comb begin
        nxt = cur_q;
        case (cur_q.st)
            ST_SAMPLE: nxt = pick_level(code_i);
            ST_FRAME: begin
                if (frame_end) begin
                    nxt = pick_level(code_i);
                end else if (tick_i) begin
                    nxt.unit = next_unit[UNIT_W-1:0];
                    nxt.pwm  = (next_unit < on_units(cur_q.code));
                end
            end
            default: nxt = pick_level(2'b00);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st   <= ST_SAMPLE;
            cur_q.code <= 2'b00;
            cur_q.unit <= '0;
            cur_q.pwm  <= 1'b0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign restart_o = (cur_q.st == ST_SAMPLE);
    assign pwm_o     = cur_q.pwm;

    assert_stop_low_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_SAMPLE && code_i == 2'b00) |=> !pwm_o);

    assert_full_high_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_SAMPLE && code_i == 2'b11) |=> pwm_o);

    assert_hold_code_R7: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_FRAME && !frame_end) |=> (cur_q.st == ST_FRAME && $stable(cur_q.code)));

    assert_unit_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_FRAME && !tick_i) |=> ($stable(cur_q.unit) && $stable(pwm_o)));

    assert_last_unit_low_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_FRAME && cur_q.unit == UNIT_W'(FRAME_UNITS - 1)) |-> !pwm_o);

    assert_frame_code_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_q.st == ST_FRAME) |-> (cur_q.code == 2'b01 || cur_q.code == 2'b10));

endmodule

// File: rtl/lumen_pwm_top.sv
module lumen_pwm_top
    import lumen_pwm_pkg::*;
#(
    parameter int TICK_CYCLES = 255
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sense_i,
    output logic       pwm_o
);

    level_code_t code_sync;
    logic        tick;
    logic        restart;

    lumen_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (sense_i),
        .sync_o  (code_sync)
    );

    lumen_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .tick_o    (tick)
    );

    lumen_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .code_i    (code_sync),
        .tick_i    (tick),
        .restart_o (restart),
        .pwm_o     (pwm_o)
    );

endmodule

// File: tb/lumen_pwm_top_tb.sv
module lumen_pwm_top_tb;

    localparam int T = 8;
    localparam int WATCHDOG_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sense = 2'b00;
    logic       pwm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    lumen_pwm_top #(.TICK_CYCLES(T)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .sense_i (sense),
        .pwm_o   (pwm)
    );

    function automatic int exp_high(input logic [1:0] c);
        case (c)
            2'b01:   return 1 * T;
            2'b10:   return 2 * T;
            2'b11:   return 4 * T;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_code(input logic [1:0] c);
        @(negedge clk);
        sense = c;
    endtask

    // count consecutive negedges where pwm equals lvl, starting now
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (pwm == lvl && n < 20 * T) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise();
        int g = 0;
        while (pwm == 1'b1 && g < 20 * T) begin g++; @(negedge clk); end
        while (pwm == 1'b0 && g < 40 * T) begin g++; @(negedge clk); end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi, lo, hi2, n;
        logic [1:0] c;
        void'($urandom(32'd1234));

        // R10: reset state
        repeat (4) @(negedge clk);
        check("R10 reset low", int'(pwm), 0);
        sense = 2'b11;
        repeat (4) @(negedge clk);
        check("R10 held in reset", int'(pwm), 0);
        rst = 1'b0;
        sense = 2'b00;
        repeat (6) @(negedge clk);
        check("R2 stop after reset", int'(pwm), 0);

        // R8 and R9: three-edge latency, 00 -> 11
        set_code(2'b11);
        repeat (2) @(negedge clk);
        check("R9 not yet through sync", int'(pwm), 0);
        @(negedge clk);
        check("R8 rises at third edge", int'(pwm), 1);
        run_len(1'b1, n);
        check("R5 full high held", n, 20 * T);

        // R8: 11 -> 00 latency
        set_code(2'b00);
        repeat (2) @(negedge clk);
        check("R9 still high", int'(pwm), 1);
        @(negedge clk);
        check("R8 falls at third edge", int'(pwm), 0);
        run_len(1'b0, n);
        check("R2 stop held", n, 20 * T);

        // R1: bit order, only bit0 lit => code 01
        set_code(2'b01);
        repeat (5 * T) @(negedge clk);
        wait_rise();
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check("R1 R3 code01 high", hi, T);
        check("R3 code01 low", lo, 3 * T);
        run_len(1'b1, hi);
        check("R3 back-to-back frame", hi, T);

        // R4: only bit1 lit => code 10
        set_code(2'b10);
        repeat (5 * T) @(negedge clk);
        wait_rise();
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check("R1 R4 code10 high", hi, 2 * T);
        check("R4 code10 low", lo, 2 * T);

        // R7: mid-frame change 01 -> 10 takes effect at boundary
        set_code(2'b01);
        repeat (5 * T) @(negedge clk);
        wait_rise();
        repeat (T / 2) @(negedge clk);
        sense = 2'b10;
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        run_len(1'b1, hi2);
        check("R7 old frame high", hi, T - T / 2);
        check("R7 old frame low", lo, 3 * T);
        check("R7 new code at boundary", hi2, 2 * T);

        // R7: mid-frame change 10 -> 11 waits for frame end
        wait_rise();
        repeat (T) @(negedge clk);
        sense = 2'b11;
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check("R7 frame finishes high", hi, T);
        check("R7 frame finishes low", lo, 2 * T);
        run_len(1'b1, n);
        check("R5 full after boundary", n, 20 * T);

        // R7: mid-frame change 01 -> 00
        set_code(2'b01);
        repeat (5 * T) @(negedge clk);
        wait_rise();
        sense = 2'b00;
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check("R7 last frame high", hi, T);
        check("R2 R7 stays low", lo, 20 * T);

        // Random levels, each held long enough to measure
        for (int i = 0; i < 16; i++) begin
            c = 2'($urandom() % 4);
            set_code(c);
            repeat (5 * T + 3) @(negedge clk);
            if (c == 2'b01 || c == 2'b10) begin
                wait_rise();
                run_len(1'b1, hi);
                run_len(1'b0, lo);
                check("R6 random high units", hi, exp_high(c));
                check("R6 random low units", lo, 4 * T - exp_high(c));
            end else begin
                run_len(c[0], n);
                check("R2 R5 random steady", n, 20 * T);
            end
        end

        finish_run();
    end

endmodule